// File: doc/BRIEF.md
# Segment to Flash Page Address Translator

This block turns a physical segment number and a page index inside that segment into an absolute page (row) address for one flash bank. A segment groups one erase block per plane. Its pages are interleaved across the planes. With two planes, odd pages sit in the neighbouring block. With four planes, pages whose index has bit 1 set also move to the upper half of the bank. The page offset inside each block is the page index divided by the plane count.

Three configuration inputs describe the bank geometry: the plane count, the pages per erase block and the blocks per bank. These inputs are captured on every clock while reset is held and are frozen once reset is released. Requests enter through a valid/ready handshake. They pass through a two-stage pipeline and leave through a second valid/ready handshake, in order. The pipeline accepts one request per cycle while the output is not stalled.

Top module: `seg_row_xlate`

## Requirements
- R1: When the captured plane count is 1, the row equals segment × pages_per_block + page index.
- R2: When the captured plane count is 2, the row equals segment × pages_per_block × 2, plus pages_per_block if page index bit 0 is 1, plus page index shifted right by 1.
- R3: When the captured plane count is 4, the row is formed as in R2, plus (blocks_per_bank / 2, rounded down) × pages_per_block if page index bit 1 is 1, with the page index shifted right by 2 instead of 1.
- R4: A captured plane count other than 1, 2 or 4 (the `cfg_planes` field carries the count as a plain binary number) gives `rsp_err` = 1 and `rsp_row` = 0 for every request. Supported counts give `rsp_err` = 0.
- R5: The configuration inputs are sampled on each clock edge while `rst` is high. Changes after reset is released have no effect on results until the next reset.
- R6: A request accepted on a clock edge, with `rsp_ready` high, shows `rsp_valid` after the next clock edge. That is the second edge counting the accepting one.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_row` and `rsp_err` hold their values.
- R8: The block holds at most two requests. With both held and `rsp_ready` low, `req_ready` is low. Responses leave in acceptance order.
- R9: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration capture window |
| cfg_planes | input | 3 | Plane count as a binary number (1, 2 or 4 supported) |
| cfg_pages_per_blk | input | PPB_W | Pages per erase block |
| cfg_blks_per_bank | input | BPB_W | Erase blocks per bank |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_seg | input | SEG_W | Physical segment number |
| req_page | input | PIDX_W | Page index within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_row | output | ROW_W | Absolute row address |
| rsp_err | output | 1 | Unsupported plane count |

## Verification
The hardest case to reach from the ports is the full pipeline with a stalled output. In that state `req_ready` must drop, and the held response must stay frozen until the stall clears. The stimulus holds `rsp_ready` low while it keeps offering requests. It confirms that exactly two are taken and that the output stays stable for several cycles. It then releases the stall and checks that both results drain in acceptance order. The frozen configuration is reached by changing the configuration inputs only after reset is released and confirming that results still follow the earlier geometry.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Plane interleave modes decoded from the captured plane count.
    typedef enum logic [1:0] {
        PL_ONE  = 2'd0,
        PL_TWO  = 2'd1,
        PL_FOUR = 2'd2,
        PL_BAD  = 2'd3
    } plane_mode_e;

endpackage

// File: rtl/seg_cfg_hold.sv
module seg_cfg_hold
    import seg_xlate_pkg::*;
#(
    parameter int PPB_W = 9,
    parameter int BPB_W = 14,
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cfg_planes,
    input  logic [PPB_W-1:0] cfg_pages_per_blk,
    input  logic [BPB_W-1:0] cfg_blks_per_bank,
    output plane_mode_e      mode_o,
    output logic [ROW_W-1:0] ppb_o,
    output logic [ROW_W-1:0] half_span_o
);

    typedef struct packed {
        plane_mode_e      mode;
        logic [ROW_W-1:0] ppb;
        logic [ROW_W-1:0] half_span;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Configuration is captured while reset is held and frozen afterwards.
    always_comb begin
        cfg_d = cfg_q;
        if (rst) begin
            unique case (cfg_planes)
                3'd1:    cfg_d.mode = PL_ONE;
                3'd2:    cfg_d.mode = PL_TWO;
                3'd4:    cfg_d.mode = PL_FOUR;
                default: cfg_d.mode = PL_BAD;
            endcase
            cfg_d.ppb       = ROW_W'(cfg_pages_per_blk);
            cfg_d.half_span = ROW_W'(cfg_blks_per_bank >> 1) * ROW_W'(cfg_pages_per_blk);
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign mode_o      = cfg_q.mode;
    assign ppb_o       = cfg_q.ppb;
    assign half_span_o = cfg_q.half_span;

endmodule

// File: rtl/seg_term_stage.sv
module seg_term_stage
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 13,
    parameter int PIDX_W = 10,
    parameter int ROW_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              in_valid_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [PIDX_W-1:0] page_i,
    input  plane_mode_e       mode_i,
    input  logic [ROW_W-1:0]  ppb_i,
    input  logic [ROW_W-1:0]  half_span_i,
    output logic              valid_o,
    output logic              err_o,
    output logic [ROW_W-1:0]  base_o,
    output logic [ROW_W-1:0]  odd_o,
    output logic [ROW_W-1:0]  half_o,
    output logic [ROW_W-1:0]  sub_o
);

    typedef struct packed {
        logic             v;
        logic             err;
        logic [ROW_W-1:0] base;
        logic [ROW_W-1:0] odd;
        logic [ROW_W-1:0] half;
        logic [ROW_W-1:0] sub;
    } term_t;

    term_t st_d, st_q;
    logic [ROW_W-1:0] seg_scaled;

    assign seg_scaled = ROW_W'(seg_i) * ppb_i;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.v = in_valid_i;
            if (in_valid_i) begin
                st_d.err  = 1'b0;
                st_d.base = '0;
                st_d.odd  = '0;
                st_d.half = '0;
                st_d.sub  = '0;
                unique case (mode_i)
                    PL_ONE: begin
                        st_d.base = seg_scaled;
                        st_d.sub  = ROW_W'(page_i);
                    end
                    PL_TWO: begin
                        st_d.base = seg_scaled << 1;
                        st_d.odd  = page_i[0] ? ppb_i : '0;
                        st_d.sub  = ROW_W'(page_i >> 1);
                    end
                    PL_FOUR: begin
                        st_d.base = seg_scaled << 1;
                        st_d.odd  = page_i[0] ? ppb_i : '0;
                        st_d.half = page_i[1] ? half_span_i : '0;
                        st_d.sub  = ROW_W'(page_i >> 2);
                    end
                    default: begin
                        st_d.err = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.v;
    assign err_o   = st_q.err;
    assign base_o  = st_q.base;
    assign odd_o   = st_q.odd;
    assign half_o  = st_q.half;
    assign sub_o   = st_q.sub;

endmodule

// File: rtl/seg_row_stage.sv
module seg_row_stage #(
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             in_valid_i,
    input  logic             err_i,
    input  logic [ROW_W-1:0] base_i,
    input  logic [ROW_W-1:0] odd_i,
    input  logic [ROW_W-1:0] half_i,
    input  logic [ROW_W-1:0] sub_i,
    output logic             valid_o,
    output logic             err_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             v;
        logic             err;
        logic [ROW_W-1:0] row;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.v = in_valid_i;
            if (in_valid_i) begin
                st_d.err = err_i;
                st_d.row = err_i ? '0 : (base_i + odd_i + half_i + sub_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.v;
    assign err_o   = st_q.err;
    assign row_o   = st_q.row;

endmodule

// File: rtl/seg_row_xlate.sv
module seg_row_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 13,
    parameter int PIDX_W = 10,
    parameter int PPB_W  = 9,
    parameter int BPB_W  = 14,
    parameter int ROW_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_planes,
    input  logic [PPB_W-1:0]  cfg_pages_per_blk,
    input  logic [BPB_W-1:0]  cfg_blks_per_bank,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [PIDX_W-1:0] req_page,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ROW_W-1:0]  rsp_row,
    output logic              rsp_err
);

    plane_mode_e      mode;
    logic [ROW_W-1:0] ppb;
    logic [ROW_W-1:0] half_span;

    logic             t_valid, t_err;
    logic [ROW_W-1:0] t_base, t_odd, t_half, t_sub;
    logic             adv_term, adv_row;

    // Each stage moves when it is empty or the stage after it moves.
    assign adv_row   = !rsp_valid || rsp_ready;
    assign adv_term  = !t_valid || adv_row;
    assign req_ready = adv_term;

    seg_cfg_hold #(
        .PPB_W(PPB_W), .BPB_W(BPB_W), .ROW_W(ROW_W)
    ) cfg_i (
        .clk               (clk),
        .rst               (rst),
        .cfg_planes        (cfg_planes),
        .cfg_pages_per_blk (cfg_pages_per_blk),
        .cfg_blks_per_bank (cfg_blks_per_bank),
        .mode_o            (mode),
        .ppb_o             (ppb),
        .half_span_o       (half_span)
    );

    seg_term_stage #(
        .SEG_W(SEG_W), .PIDX_W(PIDX_W), .ROW_W(ROW_W)
    ) term_i (
        .clk         (clk),
        .rst         (rst),
        .adv_i       (adv_term),
        .in_valid_i  (req_valid),
        .seg_i       (req_seg),
        .page_i      (req_page),
        .mode_i      (mode),
        .ppb_i       (ppb),
        .half_span_i (half_span),
        .valid_o     (t_valid),
        .err_o       (t_err),
        .base_o      (t_base),
        .odd_o       (t_odd),
        .half_o      (t_half),
        .sub_o       (t_sub)
    );

    seg_row_stage #(
        .ROW_W(ROW_W)
    ) sum_i (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (adv_row),
        .in_valid_i (t_valid),
        .err_i      (t_err),
        .base_i     (t_base),
        .odd_i      (t_odd),
        .half_i     (t_half),
        .sub_i      (t_sub),
        .valid_o    (rsp_valid),
        .err_o      (rsp_err),
        .row_o      (rsp_row)
    );

endmodule

// File: rtl/seg_row_xlate_chk.sv
module seg_row_xlate_chk
    import seg_xlate_pkg::*;
#(
    parameter int ROW_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [ROW_W-1:0] rsp_row,
    input logic             rsp_err,
    input plane_mode_e      mode
);

    logic [2:0] in_flight_q;
    logic       fire_in, fire_out;

    assign fire_in  = req_valid && req_ready;
    assign fire_out = rsp_valid && rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight_q <= '0;
        end else begin
            in_flight_q <= in_flight_q + {2'b0, fire_in} - {2'b0, fire_out};
        end
    end

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
        in_flight_q <= 3'd2);

    a_r8_full_stall: assert property (@(posedge clk) disable iff (rst)
        (in_flight_q == 3'd2 && !rsp_ready) |-> !req_ready);

    a_r6_no_phantom: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> in_flight_q != 3'd0);

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_row) && $stable(rsp_err)));

    a_r4_err_row_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> rsp_row == '0);

    a_r4_err_matches_mode: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_err == (mode == PL_BAD)));

    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode));

    a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_valid && req_ready));

endmodule

bind seg_row_xlate seg_row_xlate_chk #(.ROW_W(ROW_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_row   (rsp_row),
    .rsp_err   (rsp_err),
    .mode      (mode)
);

// File: tb/seg_row_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_row_xlate_tb_top;

    localparam int SEG_W  = 13;
    localparam int PIDX_W = 10;
    localparam int PPB_W  = 9;
    localparam int BPB_W  = 14;
    localparam int ROW_W  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        cfg_planes = 3'd1;
    logic [PPB_W-1:0]  cfg_pages_per_blk = '0;
    logic [BPB_W-1:0]  cfg_blks_per_bank = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [PIDX_W-1:0] req_page = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic [ROW_W-1:0]  rsp_row;
    logic              rsp_err;

    int n_checks = 0;
    int n_fail   = 0;

    int cur_planes;
    int cur_ppb;
    int cur_bpb;

    always #10 clk = ~clk;

    seg_row_xlate #(
        .SEG_W(SEG_W), .PIDX_W(PIDX_W), .PPB_W(PPB_W), .BPB_W(BPB_W), .ROW_W(ROW_W)
    ) dut_i (
        .clk               (clk),
        .rst               (rst),
        .cfg_planes        (cfg_planes),
        .cfg_pages_per_blk (cfg_pages_per_blk),
        .cfg_blks_per_bank (cfg_blks_per_bank),
        .req_valid         (req_valid),
        .req_ready         (req_ready),
        .req_seg           (req_seg),
        .req_page          (req_page),
        .rsp_valid         (rsp_valid),
        .rsp_ready         (rsp_ready),
        .rsp_row           (rsp_row),
        .rsp_err           (rsp_err)
    );

    function automatic int model_row(int seg, int pg, int planes, int ppb, int bpb);
        int r;
        if (planes == 1) return seg * ppb + pg;
        if (planes != 2 && planes != 4) return 0;
        r = seg * ppb * 2;
        if (pg % 2 == 1) r += ppb;
        if (planes == 4 && ((pg / 2) % 2 == 1)) r += (bpb / 2) * ppb;
        r += pg / planes;
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int planes, input int ppb, input int bpb);
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        cfg_planes = 3'(planes);
        cfg_pages_per_blk = PPB_W'(ppb);
        cfg_blks_per_bank = BPB_W'(bpb);
        cur_planes = planes;
        cur_ppb = ppb;
        cur_bpb = bpb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One isolated request; returns result and edges from acceptance to valid.
    task automatic run_one(input int seg, input int pg,
                           output longint row, output logic err, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_seg = SEG_W'(seg);
        req_page = PIDX_W'(pg);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        row = longint'(rsp_row);
        err = rsp_err;
    endtask

    task automatic check_one(input string req, input int seg, input int pg);
        longint row;
        logic   err;
        int     lat;
        run_one(seg, pg, row, err, lat);
        check(req, row, model_row(seg, pg, cur_planes, cur_ppb, cur_bpb));
        check({req, " err"}, longint'(err), 0);
        check("R6 latency", lat, 2);
    endtask

    task automatic t_reset_state();
        do_reset(1, 64, 1024);
        check("R9 rsp_valid after reset", longint'(rsp_valid), 0);
        check("R9 req_ready after reset", longint'(req_ready), 1);
    endtask

    task automatic t_one_plane();
        do_reset(1, 64, 1024);
        check_one("R1 seg5 pg10", 5, 10);
        check_one("R1 seg0 pg63", 0, 63);
        check_one("R1 seg8191 pg0", 8191, 0);
    endtask

    task automatic t_two_plane();
        do_reset(2, 64, 1024);
        check_one("R2 even page", 3, 6);
        check_one("R2 odd page", 3, 7);
        check_one("R2 last page", 100, 127);
    endtask

    task automatic t_four_plane();
        do_reset(4, 128, 4096);
        check_one("R3 pg0", 9, 0);
        check_one("R3 pg1", 9, 1);
        check_one("R3 pg2 upper half", 9, 2);
        check_one("R3 pg7", 9, 7);
        check_one("R3 last page", 1023, 511);
        do_reset(4, 64, 1023);
        check_one("R3 odd bank block count", 2, 6);
    endtask

    task automatic t_bad_planes();
        longint row;
        logic   err;
        int     lat;
        do_reset(3, 64, 1024);
        run_one(5, 7, row, err, lat);
        check("R4 count3 row", row, 0);
        check("R4 count3 err", longint'(err), 1);
        do_reset(0, 64, 1024);
        run_one(12, 3, row, err, lat);
        check("R4 count0 row", row, 0);
        check("R4 count0 err", longint'(err), 1);
    endtask

    task automatic t_cfg_frozen();
        longint row;
        logic   err;
        int     lat;
        do_reset(2, 64, 1024);
        @(negedge clk);
        cfg_planes = 3'd4;
        cfg_pages_per_blk = PPB_W'(32);
        cfg_blks_per_bank = BPB_W'(256);
        run_one(4, 3, row, err, lat);
        check("R5 cfg change ignored", row, model_row(4, 3, 2, 64, 1024));
        check("R5 cfg change err", longint'(err), 0);
    endtask

    task automatic t_stream();
        int got;
        do_reset(4, 64, 512);
        got = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i < 6) begin
                req_valid = 1'b1;
                req_seg = SEG_W'(10 + i);
                req_page = PIDX_W'(i * 3);
                check("R8 ready while streaming", longint'(req_ready), 1);
            end else begin
                req_valid = 1'b0;
            end
            if (rsp_valid) begin
                check("R6 stream order", longint'(rsp_row),
                      model_row(10 + got, got * 3, 4, 64, 512));
                got++;
            end
        end
        @(negedge clk);
        check("R6 stream count", got, 6);
    endtask

    task automatic t_backpressure();
        int taken;
        longint held;
        do_reset(2, 16, 64);
        taken = 0;
        @(negedge clk);
        rsp_ready = 1'b0;
        for (int i = 0; i < 5; i++) begin
            req_valid = 1'b1;
            req_seg = SEG_W'(20 + taken);
            req_page = PIDX_W'(taken + 1);
            if (req_ready) taken++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R8 accepted while stalled", taken, 2);
        check("R8 ready low when full", longint'(req_ready), 0);
        held = longint'(rsp_row);
        repeat (3) @(negedge clk);
        check("R7 held valid", longint'(rsp_valid), 1);
        check("R7 held row", longint'(rsp_row), held);
        check("R7 held value", held, model_row(20, 1, 2, 16, 64));
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R8 second in order", longint'(rsp_row), model_row(21, 2, 2, 16, 64));
        check("R8 second valid", longint'(rsp_valid), 1);
        @(negedge clk);
        check("R8 drained", longint'(rsp_valid), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_one_plane();
        t_two_plane();
        t_four_plane();
        t_bad_planes();
        t_cfg_frozen();
        t_stream();
        t_backpressure();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule